// File: doc/BRIEF.md
# PWM Fault Override Controller

This block sits between a four-pair complementary PWM generator and the output pins. Each pair has a high pin and a low pin. The block watches two active-low external fault inputs, A and B. When a fault asserts, the block forces the selected output pins to programmed safe levels. Each fault source has its own 16-bit control word. The word holds a safe level for every pin, a handling mode and an enable bit for every pair. Software writes and reads these words through a small register port. A pair that no asserted fault controls passes its PWM signals through unchanged.

The two handling modes work as follows. In latch mode, the override stays in force after the fault pin is released, until software issues a clear strobe. In cycle-by-cycle mode, the override is re-evaluated at every PWM period boundary, which the generator marks with a one-cycle pulse. When both sources control the same pair, fault A takes precedence. Each fault pin passes through a two-flop synchronizer before use.

Top module: `pwm_fault_guard`

## Requirements
- R1: After a synchronous active-low reset, both control words read as zero, neither source is in fault, and `pwm_out` equals `pwm_in`.
- R2: When `cfg_we` is high, a write stores `cfg_wdata` into the word picked by `cfg_sel` (0 = source A, 1 = source B). `cfg_rdata` shows the picked word combinationally. In each word, bit 8+i is the safe level of output pin i, bit 7 is the mode (0 = latch, 1 = cycle-by-cycle) and bit p is the enable for pair p+1. Bits 6:4 always read as zero. A write to one word leaves the other word unchanged.
- R3: While a source is in fault and enables pair p, output pins 2p+1 (high) and 2p (low) take that source's safe-level bits. A safe-level bit of 1 drives the pin to 1, and a bit of 0 drives it to 0.
- R4: A pair that is not enabled in any source that is currently in fault copies `pwm_in` to `pwm_out` bit for bit, in the same cycle.
- R5: In latch mode, the fault state stays set after the pin is released. A clear strobe removes it only when the synchronized pin is inactive. A clear strobe while the pin is active has no effect.
- R6: In cycle-by-cycle mode, the fault state holds between period-start pulses. At a period-start pulse the synchronized pin is sampled again, and the override is released if the pin is inactive.
- R7: When both sources are in fault and both enable the same pair, that pair takes source A's safe levels.
- R8: The fault pins are active low. After the first rising edge at which a pin is sampled low, the override appears at the outputs after the third rising edge. It does not appear before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Control word write strobe |
| cfg_sel | input | 1 | Word select: 0 = source A, 1 = source B |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Selected control word (bits 6:4 read as zero) |
| clr_a | input | 1 | Clear strobe for the source A latch |
| clr_b | input | 1 | Clear strobe for the source B latch |
| period_start | input | 1 | One-cycle pulse at each PWM period boundary |
| flt_a_n | input | 1 | Fault input A, active low, asynchronous |
| flt_b_n | input | 1 | Fault input B, active low, asynchronous |
| pwm_in | input | 8 | Raw PWM signals; bit 2p+1 is the high pin and bit 2p the low pin of pair p+1 |
| pwm_out | output | 8 | Pin drive, in the same bit order as `pwm_in` |

## Verification
`pwm_in` is random on every cycle. This separates passthrough bits from forced bits, because a forced pin stays fixed while its neighbours keep changing. Single-source runs use a partial enable mask, which shows whether the per-pair selection follows the enable bits. Holding a released pin across several cycles, and across a period-start pulse, separates the latch behaviour from the cycle-by-cycle behaviour. Clear strobes and period pulses are also issued while the pin is still low, which shows that the sampled pin takes precedence. The two-source runs first use disjoint enables and then overlapping enables with different safe levels, so A-over-B precedence can be told apart from a simple merge of the two sources.

// File: rtl/pwm_guard_pkg.sv
// Package: shared encodings for the PWM fault override controller.
// Assumes the control word places the mode bit directly below the safe levels.
package pwm_guard_pkg;

    typedef enum logic {
        MODE_LATCH = 1'b0,
        MODE_CYCLE = 1'b1
    } flt_mode_e;

    typedef enum logic {
        SRC_A = 1'b0,
        SRC_B = 1'b1
    } src_sel_e;

endpackage

// File: rtl/pwm_guard_sync.sv
// Module: pwm_guard_sync
// A chain of flops that brings an asynchronous active-low pin into the clock domain.
// Assumes STAGES >= 1. The chain resets to 1, the inactive level.
module pwm_guard_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            // Single flop: capture the pin.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= d;
            end
        end else begin : g_many
            // Shift the pin through the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/pwm_guard_source.sv
// Module: pwm_guard_source
// One fault source: its control word, its pin synchronizer and its fault state.
// Assumes the word layout {safe levels, mode, reserved, enables}. Reserved bits are stored as zero.
module pwm_guard_source
    import pwm_guard_pkg::*;
#(
    parameter int NUM_PAIRS   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [4*NUM_PAIRS-1:0]   wr_data,
    input  logic                     clr,
    input  logic                     period_start,
    input  logic                     flt_n,
    output logic [4*NUM_PAIRS-1:0]   cfg_q,
    output logic                     fault_q,
    output logic                     act
);

    localparam int PINS     = 2 * NUM_PAIRS;
    localparam int CW       = 4 * NUM_PAIRS;
    localparam int MODE_BIT = PINS - 1;
    localparam logic [CW-1:0] KEEP_MASK =
        CW'(({CW{1'b1}} << PINS) | (1 << MODE_BIT) | ((1 << NUM_PAIRS) - 1));

    logic      pin_sync;
    flt_mode_e mode;

    pwm_guard_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (flt_n),
        .q     (pin_sync)
    );

    assign act  = ~pin_sync;
    assign mode = flt_mode_e'(cfg_q[MODE_BIT]);

    // Control word storage; reserved bits are dropped on write.
    always_ff @(posedge clk) begin
        if (!rst_n)     cfg_q <= '0;
        else if (wr_en) cfg_q <= wr_data & KEEP_MASK;
    end

    // Fault state: an active pin sets it; the mode decides what clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   fault_q <= 1'b0;
        else if (act)                                 fault_q <= 1'b1;
        else if (mode == MODE_CYCLE && period_start)  fault_q <= 1'b0;
        else if (mode == MODE_LATCH && clr)           fault_q <= 1'b0;
    end

endmodule

// File: rtl/pwm_guard_mux.sv
// Module: pwm_guard_mux
// Per-pin output selection: source A override, then source B override, then raw PWM.
// Assumes pin i belongs to pair i/2 and its safe level is word bit PINS+i.
module pwm_guard_mux #(
    parameter int NUM_PAIRS = 4
) (
    input  logic [2*NUM_PAIRS-1:0] pwm_in,
    input  logic [4*NUM_PAIRS-1:0] cfg_a,
    input  logic                   fault_a,
    input  logic [4*NUM_PAIRS-1:0] cfg_b,
    input  logic                   fault_b,
    output logic [2*NUM_PAIRS-1:0] pwm_out
);

    localparam int PINS = 2 * NUM_PAIRS;

    logic [NUM_PAIRS-1:0] take_a;
    logic [NUM_PAIRS-1:0] take_b;

    generate
        for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
            assign take_a[p] = fault_a & cfg_a[p];
            assign take_b[p] = fault_b & cfg_b[p];
            for (genvar h = 0; h < 2; h++) begin : g_pin
                localparam int IDX = 2 * p + h;
                // Pin drive: the higher-priority owner wins.
                always_comb begin
                    if (take_a[p])      pwm_out[IDX] = cfg_a[PINS+IDX];
                    else if (take_b[p]) pwm_out[IDX] = cfg_b[PINS+IDX];
                    else                pwm_out[IDX] = pwm_in[IDX];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/pwm_fault_guard.sv
// Module: pwm_fault_guard (top)
// Two prioritized fault sources that override a complementary PWM pin bank.
// Assumes period_start is a one-cycle pulse and the fault pins are asynchronous and active low.
module pwm_fault_guard
    import pwm_guard_pkg::*;
#(
    parameter int NUM_PAIRS   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic                     cfg_sel,
    input  logic [4*NUM_PAIRS-1:0]   cfg_wdata,
    output logic [4*NUM_PAIRS-1:0]   cfg_rdata,
    input  logic                     clr_a,
    input  logic                     clr_b,
    input  logic                     period_start,
    input  logic                     flt_a_n,
    input  logic                     flt_b_n,
    input  logic [2*NUM_PAIRS-1:0]   pwm_in,
    output logic [2*NUM_PAIRS-1:0]   pwm_out
);

    localparam int CW = 4 * NUM_PAIRS;

    logic [CW-1:0] cfg_a_q, cfg_b_q;
    logic          fault_a_q, fault_b_q;
    logic          act_a, act_b;
    logic          wr_a, wr_b;

    assign wr_a = cfg_we & (src_sel_e'(cfg_sel) == SRC_A);
    assign wr_b = cfg_we & (src_sel_e'(cfg_sel) == SRC_B);

    pwm_guard_source #(.NUM_PAIRS(NUM_PAIRS), .SYNC_STAGES(SYNC_STAGES)) src_a_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_a),
        .wr_data      (cfg_wdata),
        .clr          (clr_a),
        .period_start (period_start),
        .flt_n        (flt_a_n),
        .cfg_q        (cfg_a_q),
        .fault_q      (fault_a_q),
        .act          (act_a)
    );

    pwm_guard_source #(.NUM_PAIRS(NUM_PAIRS), .SYNC_STAGES(SYNC_STAGES)) src_b_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_b),
        .wr_data      (cfg_wdata),
        .clr          (clr_b),
        .period_start (period_start),
        .flt_n        (flt_b_n),
        .cfg_q        (cfg_b_q),
        .fault_q      (fault_b_q),
        .act          (act_b)
    );

    // Readback of the selected control word.
    assign cfg_rdata = (src_sel_e'(cfg_sel) == SRC_B) ? cfg_b_q : cfg_a_q;

    pwm_guard_mux #(.NUM_PAIRS(NUM_PAIRS)) mux_i (
        .pwm_in  (pwm_in),
        .cfg_a   (cfg_a_q),
        .fault_a (fault_a_q),
        .cfg_b   (cfg_b_q),
        .fault_b (fault_b_q),
        .pwm_out (pwm_out)
    );

endmodule

// File: rtl/pwm_fault_guard_chk.sv
// Module: pwm_fault_guard_chk
// Property checker for pwm_fault_guard, attached by bind.
// Assumes the internal names of the top module listed in the bind below.
module pwm_fault_guard_chk #(
    parameter int NUM_PAIRS   = 4,
    parameter int SYNC_STAGES = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [4*NUM_PAIRS-1:0] cfg_rdata,
    input logic                   clr_a,
    input logic                   clr_b,
    input logic                   period_start,
    input logic                   flt_a_n,
    input logic                   flt_b_n,
    input logic [2*NUM_PAIRS-1:0] pwm_in,
    input logic [2*NUM_PAIRS-1:0] pwm_out,
    input logic [4*NUM_PAIRS-1:0] cfg_a,
    input logic [4*NUM_PAIRS-1:0] cfg_b,
    input logic                   fault_a,
    input logic                   fault_b,
    input logic                   act_a,
    input logic                   act_b
);

    localparam int PINS = 2 * NUM_PAIRS;
    localparam int MB   = PINS - 1;
    localparam int CW   = 4 * NUM_PAIRS;
    localparam logic [CW-1:0] KEEP_MASK =
        CW'(({CW{1'b1}} << PINS) | (1 << MB) | ((1 << NUM_PAIRS) - 1));

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!fault_a && !fault_b && cfg_a == '0 && cfg_b == '0));

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata & ~KEEP_MASK) == '0);

    assert_latch_hold_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_a && !cfg_a[MB] && !(clr_a && !act_a)) |=> fault_a);
    assert_latch_hold_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_b && !cfg_b[MB] && !(clr_b && !act_b)) |=> fault_b);
    assert_latch_clear_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_a[MB] && clr_a && !act_a) |=> !fault_a);

    assert_cycle_hold_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_b && cfg_b[MB] && !period_start) |=> fault_b);
    assert_cycle_release_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_b[MB] && period_start && !act_b) |=> !fault_b);

    generate
        for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
            for (genvar h = 0; h < 2; h++) begin : g_pin
                localparam int IDX = 2 * p + h;
                assert_a_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
                    (fault_a && cfg_a[p]) |-> pwm_out[IDX] == cfg_a[PINS+IDX]);
                assert_b_override_R3: assert property (@(posedge clk) disable iff (!rst_n)
                    (!(fault_a && cfg_a[p]) && fault_b && cfg_b[p])
                        |-> pwm_out[IDX] == cfg_b[PINS+IDX]);
                assert_passthru_R4: assert property (@(posedge clk) disable iff (!rst_n)
                    (!(fault_a && cfg_a[p]) && !(fault_b && cfg_b[p]))
                        |-> pwm_out[IDX] == pwm_in[IDX]);
            end
        end
        if (SYNC_STAGES == 2) begin : g_lat
            assert_fault_latency_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(rst_n, 2) && $past(rst_n, 3) && $past(!flt_a_n, 3))
                    |-> fault_a);
            assert_fault_latency_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(rst_n, 2) && $past(rst_n, 3) && $past(!flt_b_n, 3))
                    |-> fault_b);
        end
    endgenerate

endmodule

bind pwm_fault_guard pwm_fault_guard_chk #(
    .NUM_PAIRS   (NUM_PAIRS),
    .SYNC_STAGES (SYNC_STAGES)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_rdata    (cfg_rdata),
    .clr_a        (clr_a),
    .clr_b        (clr_b),
    .period_start (period_start),
    .flt_a_n      (flt_a_n),
    .flt_b_n      (flt_b_n),
    .pwm_in       (pwm_in),
    .pwm_out      (pwm_out),
    .cfg_a        (cfg_a_q),
    .cfg_b        (cfg_b_q),
    .fault_a      (fault_a_q),
    .fault_b      (fault_b_q),
    .act_a        (act_a),
    .act_b        (act_b)
);

// File: tb/pwm_fault_guard_tb_top.sv
`timescale 1ns/1ps
// Bench for pwm_fault_guard: a behavioural reference model compared on every cycle,
// plus directed checks for each requirement.
module pwm_fault_guard_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        clr_a = 1'b0;
    logic        clr_b = 1'b0;
    logic        period_start = 1'b0;
    logic        flt_a_n = 1'b1;
    logic        flt_b_n = 1'b1;
    logic [7:0]  pwm_in = '0;
    logic [7:0]  pwm_out;

    int checks = 0;
    int fails  = 0;
    bit cmp_on = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    pwm_fault_guard dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_sel      (cfg_sel),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata),
        .clr_a        (clr_a),
        .clr_b        (clr_b),
        .period_start (period_start),
        .flt_a_n      (flt_a_n),
        .flt_b_n      (flt_b_n),
        .pwm_in       (pwm_in),
        .pwm_out      (pwm_out)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    logic [15:0] m_cfg_a = '0, m_cfg_b = '0;
    bit          m_fa = 0, m_fb = 0;
    bit          qa[$] = '{1'b1, 1'b1};
    bit          qb[$] = '{1'b1, 1'b1};

    function automatic bit next_fault(bit cur, bit act, bit cyc, bit clr, bit ps);
        if (act) return 1'b1;
        if (cyc && ps) return 1'b0;
        if (!cyc && clr) return 1'b0;
        return cur;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg_a = '0; m_cfg_b = '0; m_fa = 0; m_fb = 0;
            qa = '{1'b1, 1'b1}; qb = '{1'b1, 1'b1};
        end else begin
            bit aa, ab;
            aa = !qa[$];
            ab = !qb[$];
            m_fa = next_fault(m_fa, aa, m_cfg_a[7], clr_a, period_start);
            m_fb = next_fault(m_fb, ab, m_cfg_b[7], clr_b, period_start);
            qa.push_front(flt_a_n); void'(qa.pop_back());
            qb.push_front(flt_b_n); void'(qb.pop_back());
            if (cfg_we) begin
                if (cfg_sel) m_cfg_b = cfg_wdata & 16'hFF8F;
                else         m_cfg_a = cfg_wdata & 16'hFF8F;
            end
        end
    end

    function automatic logic [7:0] model_out(logic [7:0] pin);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            if (m_fa && m_cfg_a[i/2])      r[i] = m_cfg_a[8+i];
            else if (m_fb && m_cfg_b[i/2]) r[i] = m_cfg_b[8+i];
            else                           r[i] = pin[i];
        end
        return r;
    endfunction

    function automatic string model_tag();
        if (m_fa && m_fb && ((m_cfg_a[3:0] & m_cfg_b[3:0]) != 0)) return "R7";
        if ((m_fa && m_cfg_a[3:0] != 0) || (m_fb && m_cfg_b[3:0] != 0)) return "R3";
        return "R4";
    endfunction

    // Per-cycle comparison with the model, away from the clock edge.
    always @(negedge clk) begin
        #1;
        if (cmp_on && rst_n) chk({model_tag(), " model"}, {8'h00, pwm_out}, {8'h00, model_out(pwm_in)});
    end

    // ---------------- stimulus ----------------
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        pwm_in = 8'($urandom);
        #1;
    endtask

    task automatic wr(input bit sel, input logic [15:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (4) tick();
        rst_n = 1'b1;
        cmp_on = 1;
        tick();
        // R1: reset state
        chk("R1 passthru", {8'h00, pwm_out}, {8'h00, pwm_in});
        cfg_sel = 1'b0; #1;
        chk("R1 word A", cfg_rdata, 16'h0000);
        cfg_sel = 1'b1; #1;
        chk("R1 word B", cfg_rdata, 16'h0000);

        // R2: layout, reserved bits, independence
        wr(1'b0, 16'hA5F3);
        cfg_sel = 1'b0; #1;
        chk("R2 readback A", cfg_rdata, 16'hA583);
        cfg_sel = 1'b1; #1;
        chk("R2 B untouched", cfg_rdata, 16'h0000);

        // R8 latency, R3 levels, R5 latch behaviour on source A
        wr(1'b0, 16'h5A0F);
        flt_a_n = 1'b0;
        tick();
        chk("R8 edge1", {8'h00, pwm_out}, {8'h00, pwm_in});
        tick();
        chk("R8 edge2", {8'h00, pwm_out}, {8'h00, pwm_in});
        tick();
        chk("R8 edge3 R3", {8'h00, pwm_out}, 16'h005A);
        clr_a = 1'b1; tick(); clr_a = 1'b0;
        chk("R5 clear ignored", {8'h00, pwm_out}, 16'h005A);
        flt_a_n = 1'b1;
        repeat (4) tick();
        chk("R5 hold", {8'h00, pwm_out}, 16'h005A);
        clr_a = 1'b1; tick(); clr_a = 1'b0;
        chk("R5 cleared", {8'h00, pwm_out}, {8'h00, pwm_in});
        wr(1'b0, 16'h0000);

        // R4: partial enables on source B
        wr(1'b1, 16'hFF05);
        flt_b_n = 1'b0;
        repeat (3) tick();
        chk("R4 pairs", {8'h00, pwm_out}, {8'h00, (pwm_in & 8'hCC) | 8'h33});
        flt_b_n = 1'b1;
        repeat (3) tick();
        clr_b = 1'b1; tick(); clr_b = 1'b0;
        chk("R4 released", {8'h00, pwm_out}, {8'h00, pwm_in});

        // R6: cycle-by-cycle on source B
        wr(1'b1, 16'h008F);
        flt_b_n = 1'b0;
        repeat (3) tick();
        chk("R3 inactive level", {8'h00, pwm_out}, 16'h0000);
        period_start = 1'b1; tick(); period_start = 1'b0;
        chk("R6 boundary pin low", {8'h00, pwm_out}, 16'h0000);
        flt_b_n = 1'b1;
        repeat (5) tick();
        chk("R6 hold", {8'h00, pwm_out}, 16'h0000);
        period_start = 1'b1; tick(); period_start = 1'b0;
        chk("R6 release", {8'h00, pwm_out}, {8'h00, pwm_in});

        // R7: priority
        wr(1'b0, 16'h3C03);
        wr(1'b1, 16'hA50F);
        flt_a_n = 1'b0; flt_b_n = 1'b0;
        repeat (3) tick();
        chk("R7 split", {8'h00, pwm_out}, 16'h00AC);
        wr(1'b0, 16'h3C0F);
        chk("R7 overlap", {8'h00, pwm_out}, 16'h003C);
        flt_a_n = 1'b1; flt_b_n = 1'b1;
        repeat (3) tick();
        clr_a = 1'b1; clr_b = 1'b1; tick(); clr_a = 1'b0; clr_b = 1'b0;
        chk("R5 both cleared", {8'h00, pwm_out}, {8'h00, pwm_in});

        repeat (5) tick();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule